// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of several privilege localities owns a memory-mapped host interface. The host picks a locality with the address bits above a 4 KB page. A single byte-wide ownership register in each page lets the host request the interface, give it up, force it away from a lower locality, and clear a flag that records a forced loss. Each locality has its own flags. One register holds the current owner.

Some ownership changes must first stop the command that is running. The block does not move ownership directly in those cases. It issues a one-cycle abort request to the command engine, naming the locality being aborted and the one that is to follow. The engine answers with an abort-done pulse, and only then is the hand-over applied. The engine may also abort its current owner's own command. When that abort finishes, the block signals a return to command-ready and ownership does not change. Each ownership change gives a one-cycle locality-changed strobe that names the new owner.

Top module: `loc_own_arbiter`

## Requirements
- R1: After reset no locality owns the interface (`owner_vld_o`=0, `owner_o`=8'hFF), no abort is pending, and reading any valid locality returns 8'h80.
- R2: The read byte for a valid locality L has this layout. Bit 7 is always 1. Bit 5 is 1 when L is the owner. Bit 4 is L's forced-loss flag. Bit 2 is 1 when any other locality has a pending request. Bit 1 is L's request flag. Bits 6, 3 and 0 read 0, so a pending seize is never visible. A locality number of 5 or more reads 8'h00.
- R3: Writing bit 1 (request) from a non-owner makes it owner at once when no locality owns the interface. Otherwise it sets that locality's request flag.
- R4: When the owner writes bit 5 (release) and requests are pending, the block issues an abort naming the owner and the highest-numbered requester. Ownership is kept until abort-done. When no request is pending, ownership ends at once.
- R5: A release write from a non-owner only clears its own request flag.
- R6: A seize (bit 3) is accepted only when no locality owns the interface or the writer's number is above the owner's. It is ignored when the writer already has a seize pending or a higher locality has one. Acceptance clears the seize flags of all lower localities.
- R7: In a write with bit 3 set, bits 1 and 5 of the same write have no effect.
- R8: An accepted seize issues an abort naming the current owner (8'hFF if none) as aborted and the seizer as next.
- R9: On abort-done with different aborted and next localities, the next locality becomes owner, and its request and seize flags are cleared. If the old owner lost to a seize, it loses only ownership and gets its forced-loss flag set. Otherwise it also loses its request flag.
- R10: Every change to a valid new owner pulses `chg_evt_o` for one cycle, with `chg_loc_o` set to the new owner. Giving up ownership with no successor gives no pulse.
- R11: Writing bit 4 clears the writer's forced-loss flag.
- R12: An engine abort of the owner's own command (`cmd_abort_i`) issues an abort with aborted = next = owner. Its abort-done pulses `rdy_evt_o` with `rdy_loc_o` set to the owner and leaves ownership unchanged.
- R13: Writes addressed to locality 5 or above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 15 | Host address; bits 14:12 select the locality |
| wr_en_i | input | 1 | Write strobe for the ownership register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Computed read byte for the addressed locality |
| cmd_abort_i | input | 1 | Engine aborts the owner's own command |
| abort_done_i | input | 1 | Engine finished the pending abort |
| abort_req_o | output | 1 | One-cycle abort request |
| abort_old_o | output | 8 | Locality being aborted (8'hFF for none) |
| abort_next_o | output | 8 | Locality to follow the abort |
| chg_evt_o | output | 1 | Locality-changed strobe |
| chg_loc_o | output | 8 | New owner for the strobe |
| rdy_evt_o | output | 1 | Return-to-command-ready strobe |
| rdy_loc_o | output | 8 | Locality for that strobe |
| owner_vld_o | output | 1 | A locality owns the interface |
| owner_o | output | 8 | Current owner, 8'hFF for none |

## Verification
Flags and the owner register are written at the clock edge that samples the write or the abort-done pulse. The read byte is combinational from that state, so it is valid right after that edge. The abort, locality-changed and ready strobes are registered at the same edge and last exactly one cycle. Each bench task therefore drives its inputs at the falling edge and lets one rising edge pass. It checks the strobes and the owner shortly after that edge, before the next one. The read byte is checked in the same cycle, after the address is changed.

// File: rtl/loc_own_pkg.sv
package loc_own_pkg;
   localparam int unsigned ID_W   = 8;
   localparam logic [ID_W-1:0] NO_LOC = 8'hFF;
   // bit positions in the ownership byte
   localparam int unsigned B_REQ  = 1;
   localparam int unsigned B_PEND = 2;
   localparam int unsigned B_SZ   = 3;
   localparam int unsigned B_LOST = 4;
   localparam int unsigned B_OWN  = 5;
   localparam int unsigned B_VLD  = 7;
endpackage

// File: rtl/loc_addr_dec.sv
module loc_addr_dec #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned SHIFT  = 12,
   parameter int unsigned LOC_W  = 3,
   parameter int unsigned NLOC   = 5
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [7:0]        loc_o,
   output logic              ok_o
);
   logic [LOC_W-1:0] field;
   assign field = addr_i[SHIFT +: LOC_W];
   assign loc_o = 8'(field);
   assign ok_o  = (32'(field) < NLOC);
endmodule

// File: rtl/loc_req_pick.sv
module loc_req_pick #(
   parameter int unsigned NLOC = 5
) (
   input  logic [NLOC-1:0] req_i,
   output logic            vld_o,
   output logic [7:0]      loc_o
);
   // chain: stage k holds the highest requester among k..NLOC-1
   logic [NLOC:0]     hit;
   logic [7:0]        sel [NLOC+1];
   assign hit[NLOC] = 1'b0;
   assign sel[NLOC] = 8'hFF;
   for (genvar k = NLOC - 1; k >= 0; k--) begin : g_pick
      assign hit[k] = hit[k+1] | req_i[k];
      assign sel[k] = hit[k+1] ? sel[k+1] : (req_i[k] ? 8'(k) : 8'hFF);
   end
   assign vld_o = hit[0];
   assign loc_o = sel[0];
endmodule

// File: rtl/loc_readback.sv
module loc_readback #(
   parameter int unsigned NLOC = 5
) (
   input  logic [7:0]      loc_i,
   input  logic            ok_i,
   input  logic [7:0]      owner_i,
   input  logic [NLOC-1:0] req_i,
   input  logic [NLOC-1:0] lost_i,
   output logic [7:0]      rdata_o
);
   import loc_own_pkg::*;
   logic [NLOC-1:0] self_m;
   always_comb begin
      self_m  = '0;
      rdata_o = '0;
      if (ok_i) begin
         self_m[loc_i[$clog2(NLOC)-1:0]] = 1'b1;
         rdata_o[B_VLD]  = 1'b1;
         rdata_o[B_OWN]  = (owner_i == loc_i);
         rdata_o[B_LOST] = lost_i[loc_i[$clog2(NLOC)-1:0]];
         rdata_o[B_PEND] = |(req_i & ~self_m);
         rdata_o[B_REQ]  = req_i[loc_i[$clog2(NLOC)-1:0]];
      end
   end
endmodule

// File: rtl/loc_own_arbiter.sv
module loc_own_arbiter #(
   parameter int unsigned NLOC   = 5,
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned SHIFT  = 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   input  logic              cmd_abort_i,
   input  logic              abort_done_i,
   output logic              abort_req_o,
   output logic [7:0]        abort_old_o,
   output logic [7:0]        abort_next_o,
   output logic              chg_evt_o,
   output logic [7:0]        chg_loc_o,
   output logic              rdy_evt_o,
   output logic [7:0]        rdy_loc_o,
   output logic              owner_vld_o,
   output logic [7:0]        owner_o
);
   import loc_own_pkg::*;
   localparam int unsigned LOC_W = $clog2(NLOC);

   initial begin
      if (NLOC < 2 || NLOC > 254) $error("NLOC out of range");
      if (SHIFT + LOC_W > ADDR_W) $error("address too narrow for locality field");
   end

   typedef struct packed {
      logic [NLOC-1:0] req;
      logic [NLOC-1:0] sz;
      logic [NLOC-1:0] lost;
      logic [7:0]      own;
   } own_t;

   own_t       cur_q, st_a, st_b;
   logic [7:0] nxt_q, abt_q, nxt_a, abt_a, nxt_b, abt_b;
   logic       ev_a, ev_b, rdy_a, ab_b;
   logic [7:0] evl_a, evl_b, rdyl_a;
   logic [7:0] wloc;
   logic       wok, pick_vld;
   logic [7:0] pick_loc;

   // hand ownership to n, updating the leaving owner's flags
   function automatic own_t f_move(own_t s, logic [7:0] n);
      own_t r;
      logic by_seize;
      r = s;
      if (s.own != n && s.own < 8'(NLOC)) begin
         by_seize = (n < 8'(NLOC)) && s.sz[n[LOC_W-1:0]];
         if (by_seize) r.lost[s.own[LOC_W-1:0]] = 1'b1;
         else          r.req[s.own[LOC_W-1:0]]  = 1'b0;
      end
      r.own = n;
      if (n < 8'(NLOC)) begin
         r.req[n[LOC_W-1:0]] = 1'b0;
         r.sz[n[LOC_W-1:0]]  = 1'b0;
      end
      return r;
   endfunction

   loc_addr_dec #(.ADDR_W(ADDR_W), .SHIFT(SHIFT), .LOC_W(LOC_W), .NLOC(NLOC)) u_dec (
      .addr_i(addr_i), .loc_o(wloc), .ok_o(wok));

   // stage A: completion of a pending abort
   always_comb begin
      st_a = cur_q; nxt_a = nxt_q; abt_a = abt_q;
      ev_a = 1'b0; evl_a = NO_LOC; rdy_a = 1'b0; rdyl_a = NO_LOC;
      if (abort_done_i && nxt_q < 8'(NLOC)) begin
         if (abt_q == nxt_q) begin
            rdy_a  = 1'b1;
            rdyl_a = nxt_q;
         end else begin
            ev_a  = (cur_q.own != nxt_q);
            evl_a = nxt_q;
            st_a  = f_move(cur_q, nxt_q);
         end
         nxt_a = NO_LOC;
         abt_a = NO_LOC;
      end
   end

   loc_req_pick #(.NLOC(NLOC)) u_pick (.req_i(st_a.req), .vld_o(pick_vld), .loc_o(pick_loc));

   // stage B: engine abort and host write
   always_comb begin
      logic [7:0]      v, tgt;
      logic            mv;
      logic [NLOC-1:0] bit_l, low_m, high_m;
      st_b = st_a; nxt_b = nxt_a; abt_b = abt_a;
      ab_b = 1'b0; ev_b = ev_a; evl_b = evl_a;
      v = wdata_i; tgt = st_a.own; mv = 1'b1;
      bit_l = '0; low_m = '0; high_m = '0;
      if (cmd_abort_i && st_a.own < 8'(NLOC)) begin
         ab_b = 1'b1; abt_b = st_a.own; nxt_b = st_a.own;
      end
      if (wr_en_i && wok) begin
         bit_l[wloc[LOC_W-1:0]] = 1'b1;
         low_m  = bit_l - 1'b1;
         high_m = ~(low_m | bit_l);
         if (v[B_SZ]) begin
            v[B_REQ] = 1'b0;
            v[B_OWN] = 1'b0;
         end
         if (v[B_OWN]) begin
            if (st_a.own == wloc) begin
               if (pick_vld) begin
                  mv = 1'b0; ab_b = 1'b1; abt_b = wloc; nxt_b = pick_loc;
               end else begin
                  tgt = NO_LOC;
               end
            end else begin
               st_b.req = st_b.req & ~bit_l;
            end
         end
         if (v[B_LOST]) st_b.lost = st_b.lost & ~bit_l;
         if (v[B_SZ] && (st_a.own >= 8'(NLOC) || wloc > st_a.own) &&
             !(|(st_b.sz & bit_l)) && !(|(st_b.sz & high_m))) begin
            st_b.sz = (st_b.sz & ~low_m) | bit_l;
            mv = 1'b0; ab_b = 1'b1; abt_b = st_a.own; nxt_b = wloc;
         end
         if (v[B_REQ] && st_a.own != wloc) begin
            if (st_a.own < 8'(NLOC)) st_b.req = st_b.req | bit_l;
            else                     tgt = wloc;
         end
         if (mv) begin
            if (st_b.own != tgt && tgt < 8'(NLOC)) begin
               ev_b = 1'b1; evl_b = tgt;
            end
            st_b = f_move(st_b, tgt);
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cur_q <= '{req: '0, sz: '0, lost: '0, own: NO_LOC};
         nxt_q <= NO_LOC; abt_q <= NO_LOC;
         abort_req_o <= 1'b0; abort_old_o <= NO_LOC; abort_next_o <= NO_LOC;
         chg_evt_o <= 1'b0; chg_loc_o <= NO_LOC;
         rdy_evt_o <= 1'b0; rdy_loc_o <= NO_LOC;
      end else begin
         cur_q <= st_b; nxt_q <= nxt_b; abt_q <= abt_b;
         abort_req_o  <= ab_b;
         abort_old_o  <= abt_b;
         abort_next_o <= nxt_b;
         chg_evt_o <= ev_b;  chg_loc_o <= evl_b;
         rdy_evt_o <= rdy_a; rdy_loc_o <= rdyl_a;
      end
   end

   loc_readback #(.NLOC(NLOC)) u_rd (
      .loc_i(wloc), .ok_i(wok), .owner_i(cur_q.own),
      .req_i(cur_q.req), .lost_i(cur_q.lost), .rdata_o(rdata_o));

   assign owner_o     = cur_q.own;
   assign owner_vld_o = (cur_q.own != NO_LOC);
endmodule

// File: rtl/loc_own_checker.sv
module loc_own_checker #(
   parameter int unsigned NLOC = 5
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [7:0] owner_o,
   input logic       chg_evt_o,
   input logic [7:0] chg_loc_o,
   input logic [NLOC-1:0] sz_flags,
   input logic [NLOC-1:0] req_flags,
   input logic       wok,
   input logic [7:0] rdata_o
);
   // R1
   owner_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (owner_o == 8'hFF) || (owner_o < 8'(NLOC)));
   // R6
   seize_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(sz_flags));
   // R10
   chg_names_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chg_evt_o |-> (chg_loc_o == owner_o));
   // R9
   owner_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (owner_o < 8'(NLOC)) |-> !req_flags[owner_o[$clog2(NLOC)-1:0]]);
   // R2
   valid_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wok |-> (rdata_o[7] && !rdata_o[3]));
endmodule

bind loc_own_arbiter loc_own_checker #(.NLOC(NLOC)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .owner_o(owner_o),
   .chg_evt_o(chg_evt_o), .chg_loc_o(chg_loc_o),
   .sz_flags(cur_q.sz), .req_flags(cur_q.req),
   .wok(wok), .rdata_o(rdata_o));

// File: tb/tb_loc_own_arbiter.sv
module tb_loc_own_arbiter;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [14:0] addr = '0;
   logic        wr_en = 0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        cmd_abort = 0, abort_done = 0;
   logic        abort_req, chg_evt, rdy_evt, owner_vld;
   logic [7:0]  abort_old, abort_next, chg_loc, rdy_loc, owner;
   int          n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   loc_own_arbiter dut (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
      .wdata_i(wdata), .rdata_o(rdata), .cmd_abort_i(cmd_abort),
      .abort_done_i(abort_done), .abort_req_o(abort_req),
      .abort_old_o(abort_old), .abort_next_o(abort_next),
      .chg_evt_o(chg_evt), .chg_loc_o(chg_loc), .rdy_evt_o(rdy_evt),
      .rdy_loc_o(rdy_loc), .owner_vld_o(owner_vld), .owner_o(owner));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one write, then sample just after the capturing edge
   task automatic wr(int loc, logic [7:0] d);
      @(negedge clk);
      addr = 15'(loc) << 12; wdata = d; wr_en = 1;
      @(posedge clk); #1;
      wr_en = 0;
   endtask

   task automatic done();
      @(negedge clk); abort_done = 1;
      @(posedge clk); #1; abort_done = 0;
   endtask

   task automatic rd(int loc, string req, logic [7:0] exp);
      addr = 15'(loc) << 12; #1;
      chk(req, rdata, exp);
   endtask

   task automatic t_reset();
      chk("R1 owner_vld", owner_vld, 0);
      chk("R1 owner", owner, 8'hFF);
      rd(0, "R1 read loc0", 8'h80);
      rd(4, "R1 read loc4", 8'h80);
   endtask

   task automatic t_grant_pending();
      wr(2, 8'h02);
      chk("R3 grant owner", owner, 2);
      chk("R10 chg evt", chg_evt, 1);
      chk("R10 chg loc", chg_loc, 2);
      rd(2, "R2 owner read", 8'hA0);
      wr(1, 8'h02);
      chk("R3 no grant when owned", owner, 2);
      rd(1, "R2 req read", 8'h82);
      rd(3, "R2 pending read", 8'h84);
      rd(2, "R2 owner pending read", 8'hA4);
      rd(6, "R2 invalid read", 8'h00);
   endtask

   task automatic t_release_handover();
      wr(3, 8'h02);
      wr(2, 8'h20);
      chk("R4 abort req", abort_req, 1);
      chk("R4 abort old", abort_old, 2);
      chk("R4 abort next highest", abort_next, 3);
      chk("R4 owner kept", owner, 2);
      done();
      chk("R9 new owner", owner, 3);
      chk("R10 chg on handover", chg_evt, 1);
      chk("R10 chg loc handover", chg_loc, 3);
      rd(2, "R9 old owner cleared", 8'h84);
      rd(3, "R9 new owner req cleared", 8'hA4);
   endtask

   task automatic t_nonowner_release();
      wr(1, 8'h20);
      rd(1, "R5 own req cleared", 8'h80);
      chk("R5 owner unchanged", owner, 3);
   endtask

   task automatic t_seize();
      wr(1, 8'h08);
      chk("R6 lower seize no abort", abort_req, 0);
      wr(4, 8'h2A);
      chk("R8 seize abort", abort_req, 1);
      chk("R8 seize old", abort_old, 3);
      chk("R8 seize next", abort_next, 4);
      rd(4, "R7 req bit ignored, seize hidden", 8'h80);
      chk("R7 owner unchanged", owner, 3);
      done();
      chk("R9 seizer owns", owner, 4);
      rd(3, "R9 seized flagged", 8'h90);
      wr(3, 8'h10);
      rd(3, "R11 lost cleared", 8'h80);
   endtask

   task automatic t_release_none();
      wr(4, 8'h20);
      chk("R4 no owner left", owner_vld, 0);
      chk("R10 no chg on empty", chg_evt, 0);
      wr(6, 8'h02);
      chk("R13 invalid write ignored", owner_vld, 0);
   endtask

   task automatic t_seize_chain();
      wr(0, 8'h08);
      chk("R8 seize unowned old", abort_old, 8'hFF);
      chk("R8 seize unowned next", abort_next, 0);
      done();
      chk("R9 unowned seize owner", owner, 0);
      wr(3, 8'h08);
      chk("R6 higher seize accepted", abort_req, 1);
      wr(2, 8'h08);
      chk("R6 blocked by higher seize", abort_req, 0);
      wr(4, 8'h08);
      chk("R6 top seize accepted", abort_next, 4);
      done();
      chk("R9 top owner", owner, 4);
      rd(0, "R9 old owner flagged", 8'h90);
   endtask

   task automatic t_self_abort();
      @(negedge clk); cmd_abort = 1;
      @(posedge clk); #1; cmd_abort = 0;
      chk("R12 self abort old", abort_old, 4);
      chk("R12 self abort next", abort_next, 4);
      done();
      chk("R12 ready strobe", rdy_evt, 1);
      chk("R12 ready loc", rdy_loc, 4);
      chk("R12 no chg", chg_evt, 0);
      chk("R12 owner kept", owner, 4);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            @(negedge clk); rst_n = 1;
            #1;
            t_reset();
            t_grant_pending();
            t_release_handover();
            t_nonowner_release();
            t_seize();
            t_release_none();
            t_seize_chain();
            t_self_abort();
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule